// File: doc/BRIEF.md
# Coalescing Store Buffer with Read Bypass

This block sits between a write-through cache and main memory. Stores are absorbed into a small queue so the processor can retire them at once. Each queue entry holds one aligned block of `WORDS` words and a per-word valid mask. A store that lands in a block already held in the queue is folded into that entry, so several stores to one block leave as one memory write.

Read misses come in on a separate lookup port. If the requested word is held in the queue, it is returned on the spot from the buffer. Otherwise the read claims the memory port ahead of every queued write. This is safe because the queue holds no newer copy of that word. When no read needs memory, entries leave for memory oldest first, one entry per granted write transaction. A dirty victim can be pushed in as ordinary stores, so its write-back follows the demand read.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the queue is empty: `stReady` is 1, `rdFwd` is 0, and `memReq` stays 0 while no read needs memory.
- R2: A store to a block not held in the queue takes a free entry. Its word is marked valid and the other words of the entry are zero.
- R3: A store to a block already held in the queue merges into that entry. It sets that word's mask bit, and a later store to the same word replaces the data. The whole entry leaves as one memory write.
- R4: When every entry is in use and a store can neither merge nor reuse an entry freed in the same cycle, `stReady` is 0 and the store is not taken. A store that merges is accepted even when the queue is full.
- R5: While no read needs memory and the queue is not empty, a write request for the oldest entry is presented. Its address is held until `memGnt`, and each grant removes exactly one entry.
- R6: A read whose word is valid in the queue gives `rdFwd`=1 and the buffered word on `rdFwdData` in the same cycle. No memory read is requested for it.
- R7: A read whose word is not valid in the queue, whether the block is absent or only other words of it are held, drives a memory read at `rdAddr` (`memWrite`=0). Queued writes wait for it.
- R8: A store to the oldest entry's block in the cycle that entry's write is granted does not merge into it. It takes a new entry and reaches memory in a later write.
- R9: A memory write carries the block's base word address (low log2(`WORDS`) bits zero). `memWData` word i sits at bits [i*DATA_W +: DATA_W], and `memMask` bit i flags word i as valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stValid | input | 1 | Store request |
| stReady | output | 1 | Store accepted this cycle when high with stValid |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data word |
| rdValid | input | 1 | Read-miss lookup request |
| rdAddr | input | ADDR_W | Read word address |
| rdFwd | output | 1 | Requested word is served from the queue |
| rdFwdData | output | DATA_W | Forwarded word |
| memReq | output | 1 | Memory transaction request |
| memWrite | output | 1 | 1 = write of the oldest entry, 0 = read at rdAddr |
| memAddr | output | ADDR_W | Memory word address |
| memWData | output | WORDS*DATA_W | Block write data |
| memMask | output | WORDS | Valid-word mask of the write |
| memGnt | input | 1 | Memory accepts the presented transaction |

## Verification
Corrupted entry state shows up at the memory port as a write with a wrong address, mask or data word. It can also show up as a write too many or one missing. The bench therefore compares every granted write against a queue of hand-computed blocks, and a fault shows by the time the affected entry drains. A broken lookup shows in the same cycle as a wrong `rdFwd` or a read that is not steered to memory. A broken occupancy count shows as a wrong `stReady` on the next full-queue store, or as extra or missing drain writes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic doAlloc;   // write store into a fresh entry at allocIdx
    logic doMerge;   // fold store into the matching entry
    logic doPop;     // oldest entry left for memory
    logic rdToMem;   // read miss owns the memory port
  } wbCtrl_t;
endpackage

// File: rtl/wbuf_data.sv
module wbuf_data
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbCtrl_t           ctl,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic [IDX_W-1:0]  popIdx,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              stMatch,
  output logic [IDX_W-1:0]  stMatchIdx,
  output logic              rdFwd,
  output logic [DATA_W-1:0] rdFwdData,
  output logic [BLK_W-1:0]  headBlk,
  output logic [LINE_W-1:0] headData,
  output logic [WORDS-1:0]  headMask,
  output logic [DEPTH-1:0]  entValid
);
  logic [BLK_W-1:0]             entBlk  [DEPTH];
  logic [WORDS-1:0]             entMask [DEPTH];
  logic [WORDS-1:0][DATA_W-1:0] entData [DEPTH];

  logic [BLK_W-1:0] stBlk, rdBlk;
  logic [OFF_W-1:0] stWord, rdWord;
  assign stBlk  = stAddr[ADDR_W-1:OFF_W];
  assign stWord = stAddr[OFF_W-1:0];
  assign rdBlk  = rdAddr[ADDR_W-1:OFF_W];
  assign rdWord = rdAddr[OFF_W-1:0];

  logic [DEPTH-1:0] stHitVec, rdHitVec;
  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign stHitVec[g] = entValid[g] && (entBlk[g] == stBlk);
    assign rdHitVec[g] = entValid[g] && (entBlk[g] == rdBlk) && entMask[g][rdWord];
  end

  logic [IDX_W-1:0] rdSel;
  always_comb begin
    stMatchIdx = '0;
    rdSel      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (stHitVec[i]) stMatchIdx = IDX_W'(i);
      if (rdHitVec[i]) rdSel      = IDX_W'(i);
    end
  end

  assign stMatch   = |stHitVec;
  assign rdFwd     = |rdHitVec;
  assign rdFwdData = entData[rdSel][rdWord];
  assign headBlk   = entBlk[popIdx];
  assign headData  = entData[popIdx];
  assign headMask  = entMask[popIdx];

  // a fresh entry: only the stored word is set, the rest are zero
  logic [WORDS-1:0][DATA_W-1:0] freshLine;
  logic [WORDS-1:0]             freshMask;
  always_comb begin
    freshLine         = '0;
    freshLine[stWord] = stData;
    freshMask         = '0;
    freshMask[stWord] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entBlk[i]  <= '0;
        entMask[i] <= '0;
        entData[i] <= '0;
      end
    end else begin
      if (ctl.doPop) begin
        entValid[popIdx] <= 1'b0;
        entMask[popIdx]  <= '0;
      end
      if (ctl.doMerge) begin
        entData[stMatchIdx][stWord] <= stData;
        entMask[stMatchIdx][stWord] <= 1'b1;
      end
      // alloc after pop: on a full queue the freed slot is reused at once
      if (ctl.doAlloc) begin
        entValid[allocIdx] <= 1'b1;
        entBlk[allocIdx]   <= stBlk;
        entData[allocIdx]  <= freshLine;
        entMask[allocIdx]  <= freshMask;
      end
    end
  end
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             stMatch,
  input  logic [IDX_W-1:0] stMatchIdx,
  input  logic             rdValid,
  input  logic             rdFwd,
  input  logic             memGnt,
  output wbCtrl_t          ctl,
  output logic [IDX_W-1:0] allocIdx,
  output logic [IDX_W-1:0] popIdx,
  output logic             stReady,
  output logic             memReq,
  output logic             memWrite,
  output logic [CNT_W-1:0] occCount
);
  logic [IDX_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] cntQ;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  logic rdToMem, haveData, drainGo, mergeOk, spaceOk;
  always_comb begin
    rdToMem  = rdValid && !rdFwd;
    haveData = (cntQ != '0);
    memReq   = rdToMem || haveData;
    memWrite = !rdToMem && haveData;
    drainGo  = memWrite && memGnt;
    // the head cannot take a merge in the cycle it is handed to memory
    mergeOk  = stMatch && !(drainGo && (stMatchIdx == headQ));
    spaceOk  = (cntQ < CNT_W'(DEPTH)) || drainGo;
    stReady  = mergeOk || spaceOk;
    ctl.doMerge = stValid && mergeOk;
    ctl.doAlloc = stValid && !mergeOk && spaceOk;
    ctl.doPop   = drainGo;
    ctl.rdToMem = rdToMem;
  end

  assign allocIdx = tailQ;
  assign popIdx   = headQ;
  assign occCount = cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
    end else begin
      if (ctl.doPop)   headQ <= bump(headQ);
      if (ctl.doAlloc) tailQ <= bump(tailQ);
      case ({ctl.doAlloc, ctl.doPop})
        2'b10:   cntQ <= cntQ + CNT_W'(1);
        2'b01:   cntQ <= cntQ - CNT_W'(1);
        default: cntQ <= cntQ;
      endcase
    end
  end
endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stValid,
  output logic                    stReady,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [DATA_W-1:0]       stData,
  input  logic                    rdValid,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic                    rdFwd,
  output logic [DATA_W-1:0]       rdFwdData,
  output logic                    memReq,
  output logic                    memWrite,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORDS*DATA_W-1:0] memWData,
  output logic [WORDS-1:0]        memMask,
  input  logic                    memGnt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OFF_W = $clog2(WORDS);
  localparam int BLK_W = ADDR_W - OFF_W;

  wbCtrl_t                 ctl;
  logic [IDX_W-1:0]        allocIdx, popIdx, stMatchIdx;
  logic                    stMatch;
  logic [BLK_W-1:0]        headBlk;
  logic [WORDS*DATA_W-1:0] headData;
  logic [WORDS-1:0]        headMask;
  logic [DEPTH-1:0]        entValid;
  logic [CNT_W-1:0]        occCount;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stMatch(stMatch),
    .stMatchIdx(stMatchIdx), .rdValid(rdValid), .rdFwd(rdFwd), .memGnt(memGnt),
    .ctl(ctl), .allocIdx(allocIdx), .popIdx(popIdx), .stReady(stReady),
    .memReq(memReq), .memWrite(memWrite), .occCount(occCount)
  );

  wbuf_data #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .allocIdx(allocIdx), .popIdx(popIdx),
    .stAddr(stAddr), .stData(stData), .rdAddr(rdAddr),
    .stMatch(stMatch), .stMatchIdx(stMatchIdx), .rdFwd(rdFwd), .rdFwdData(rdFwdData),
    .headBlk(headBlk), .headData(headData), .headMask(headMask), .entValid(entValid)
  );

  assign memAddr  = ctl.rdToMem ? rdAddr : {headBlk, {OFF_W{1'b0}}};
  assign memWData = headData;
  assign memMask  = memWrite ? headMask : '0;
endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int DEPTH  = 4,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OFF_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              stValid,
  input logic              stReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdFwd,
  input logic              memReq,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORDS-1:0]  memMask,
  input logic              memGnt,
  input logic [CNT_W-1:0]  occCount,
  input logic [DEPTH-1:0]  entValid
);
  a_r1_idle_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (occCount == '0 && !rdValid) |-> !memReq);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (occCount <= CNT_W'(DEPTH)) && (CNT_W'($countones(entValid)) == occCount));

  a_r4_ready_with_room: assert property (@(posedge clk) disable iff (!rstN)
    (occCount < CNT_W'(DEPTH)) |-> stReady);

  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && !memGnt) |=>
      ((rdValid && !rdFwd) || (memReq && memWrite && $stable(memAddr))));

  a_r5_one_pop: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && memGnt && !stValid) |=> (occCount == $past(occCount) - CNT_W'(1)));

  a_r6_fwd_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdFwd) |-> !(memReq && !memWrite));

  a_r7_read_first: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdFwd) |-> (memReq && !memWrite && memAddr == rdAddr));

  a_r9_aligned_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> (memAddr[OFF_W-1:0] == '0 && memMask != '0));
endmodule

bind merge_write_buffer wbuf_checker #(.DEPTH(DEPTH), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .rdValid(rdValid),
  .rdAddr(rdAddr), .rdFwd(rdFwd), .memReq(memReq), .memWrite(memWrite),
  .memAddr(memAddr), .memMask(memMask), .memGnt(memGnt),
  .occCount(occCount), .entValid(entValid)
);

// File: tb/test_merge_write_buffer.sv
module test_merge_write_buffer;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 4;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int LINE_W = WORDS * DATA_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0, stReady;
  logic [ADDR_W-1:0] stAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic rdValid = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic rdFwd;
  logic [DATA_W-1:0] rdFwdData;
  logic memReq, memWrite;
  logic [ADDR_W-1:0] memAddr;
  logic [LINE_W-1:0] memWData;
  logic [WORDS-1:0] memMask;
  logic memGnt = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  merge_write_buffer #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W))
    i_merge_write_buffer (.*);

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [LINE_W-1:0] d;
    logic [WORDS-1:0]  m;
  } exp_t;
  exp_t expQ[$];
  int nRun = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] word(input int w, input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = '0;
    r[w*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  task automatic expectWrite(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d,
                             input logic [WORDS-1:0] m);
    exp_t e;
    e.a = a; e.d = d; e.m = m;
    expQ.push_back(e);
  endtask

  task automatic doStore(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d;
    #1;
    while (!stReady) begin @(negedge clk); #1; end
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic waitDrain();
    int n;
    n = 0;
    while (expQ.size() != 0 && n < 500) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    #1;
    check(expQ.size() == 0, "R5", "writes still missing", LINE_W'(expQ.size()), '0);
    check(memReq == 1'b0, "R5", "memReq after drain", LINE_W'(memReq), '0);
  endtask

  // monitor: compare every granted write against the expected queue
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (rstN && memReq && memWrite && memGnt) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected write at", LINE_W'(memAddr), '0);
        end else begin
          e = expQ.pop_front();
          check(memAddr == e.a, "R9", "write address", LINE_W'(memAddr), LINE_W'(e.a));
          check(memWData == e.d, "R3", "write data", memWData, e.d);
          check(memMask == e.m, "R3", "write mask", LINE_W'(memMask), LINE_W'(e.m));
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      nFail++;
      $display("FAIL R5 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(stReady == 1'b1, "R1", "stReady after reset", LINE_W'(stReady), 1);
    check(memReq == 1'b0, "R1", "memReq after reset", LINE_W'(memReq), 0);
    check(rdFwd == 1'b0, "R1", "rdFwd after reset", LINE_W'(rdFwd), 0);

    // R2 R3 R9: alloc, merge, overwrite, second block
    doStore(16'h0010, 32'hA0);
    doStore(16'h0012, 32'hA2);
    doStore(16'h0010, 32'hB0);
    doStore(16'h0025, 32'hC1);
    @(negedge clk); #1;
    check(memReq && memWrite, "R5", "write requested", LINE_W'({memReq, memWrite}), 3);
    check(memAddr == 16'h0010, "R5", "oldest entry first", LINE_W'(memAddr), 16'h0010);
    expectWrite(16'h0010, word(0, 32'hB0) | word(2, 32'hA2), 4'b0101);
    expectWrite(16'h0024, word(1, 32'hC1), 4'b0010);
    memGnt = 1'b1;
    waitDrain();
    memGnt = 1'b0;

    // R4 full queue
    doStore(16'h0100, 32'h1);
    doStore(16'h0200, 32'h2);
    doStore(16'h0300, 32'h3);
    doStore(16'h0400, 32'h4);
    @(negedge clk);
    stValid = 1'b1; stAddr = 16'h0500; stData = 32'h5;
    #1;
    check(stReady == 1'b0, "R4", "stall when full", LINE_W'(stReady), 0);
    @(negedge clk);
    stAddr = 16'h0203; stData = 32'h77;
    #1;
    check(stReady == 1'b1, "R4", "merge accepted when full", LINE_W'(stReady), 1);
    @(negedge clk);
    stValid = 1'b0;
    expectWrite(16'h0100, word(0, 32'h1), 4'b0001);
    expectWrite(16'h0200, word(0, 32'h2) | word(3, 32'h77), 4'b1001);
    expectWrite(16'h0300, word(0, 32'h3), 4'b0001);
    expectWrite(16'h0400, word(0, 32'h4), 4'b0001);
    memGnt = 1'b1;
    waitDrain();
    memGnt = 1'b0;

    // R6 R7 read lookup and bypass
    doStore(16'h0042, 32'hAAAA);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = 16'h0042;
    #1;
    check(rdFwd == 1'b1, "R6", "forward hit", LINE_W'(rdFwd), 1);
    check(rdFwdData == 32'hAAAA, "R6", "forward data", LINE_W'(rdFwdData), 32'hAAAA);
    check(memWrite == 1'b1, "R6", "no memory read on hit", LINE_W'(memWrite), 1);
    @(negedge clk);
    rdAddr = 16'h0041;
    #1;
    check(rdFwd == 1'b0, "R7", "invalid word not forwarded", LINE_W'(rdFwd), 0);
    check(memReq && !memWrite, "R7", "read owns port", LINE_W'({memReq, memWrite}), 2);
    check(memAddr == 16'h0041, "R7", "read address", LINE_W'(memAddr), 16'h0041);
    @(negedge clk);
    rdAddr = 16'h0900; memGnt = 1'b1;
    #1;
    check(!memWrite && memAddr == 16'h0900, "R7", "absent block read first",
          LINE_W'(memAddr), 16'h0900);
    @(negedge clk);
    rdValid = 1'b0; memGnt = 1'b0;
    #1;
    check(memWrite && memAddr == 16'h0040, "R7", "queued write kept",
          LINE_W'(memAddr), 16'h0040);
    expectWrite(16'h0040, word(2, 32'hAAAA), 4'b0100);
    memGnt = 1'b1;
    waitDrain();
    memGnt = 1'b0;

    // R8 store to head block in its grant cycle
    doStore(16'h0080, 32'h11);
    expectWrite(16'h0080, word(0, 32'h11), 4'b0001);
    expectWrite(16'h0080, word(1, 32'h22), 4'b0010);
    @(negedge clk);
    stValid = 1'b1; stAddr = 16'h0081; stData = 32'h22; memGnt = 1'b1;
    #1;
    check(stReady == 1'b1, "R8", "store accepted during drain", LINE_W'(stReady), 1);
    @(negedge clk);
    stValid = 1'b0;
    waitDrain();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule